// File: doc/BRIEF.md
# Pseudo-Random Threshold Pulse Modulator

This block turns an N-bit level into a one-bit stream in which the fraction of ones tracks the level divided by full scale. Instead of testing the level against a ramp counter, each cycle it tests the level against a pseudo-random number. The number is the low N bits of a wider M-bit maximal-length shift register. Because the random value does not sweep in order, the switching energy spreads across the spectrum rather than piling up at the harmonics of a fixed ramp. The only repetition left in the stream is the shift register's period, 2^M-1 enabled cycles.

A new level is captured only when the load strobe is high. It governs the comparison from the next clock onward. While enable is low, the shift register holds its state and the output is driven low. An analog low-pass filter outside the block recovers the average.

Top module: `lfsr_dither_pwm`

## Requirements
- R1: While rst is high at a rising clock edge, pulseOut becomes 0, the held level becomes 0 and the shift register loads the seed 16'hACE1.
- R2: On an enabled edge, pulseOut becomes 1 exactly when the low LEVEL_W bits of the shift register before that edge are strictly less than the held level before that edge; otherwise it becomes 0.
- R3: The held level takes levelIn only at an edge where levelLoad is high. A level loaded at one edge first affects pulseOut at the following enabled edge. Loading works whether or not enable is high.
- R4: On each enabled edge the 16-bit register shifts toward its MSB, and the new bit 0 is the XOR of old bits 15, 14, 12 and 3 (taps 16, 15, 13, 4).
- R5: At an edge with enable low, pulseOut becomes 0 and the shift register keeps its value. The sequence therefore resumes where it stopped once enable returns.
- R6: With a held level of 0, pulseOut is never 1.
- R7: Over any 2^16-1 consecutive enabled cycles at a constant level L, the number of ones is 256*L minus 1 if L is nonzero, and 0 if L is zero.
- R8: The shift register never holds the all-zero state.
- R9: With the level at full scale 255, pulseOut is 0 only on cycles where the random byte equals 255, which gives 65279 ones per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances the random source and enables the output |
| levelIn | input | LEVEL_W | Requested density level |
| levelLoad | input | 1 | Captures levelIn into the held level |
| pulseOut | output | 1 | Registered pulse stream |

## Verification
On every cycle, the assertions check the comparison against the held level, the shift rule of the random source, the freeze and forced-low output while disabled, the load behaviour of the held level, and that the all-zero state is never reached. What no per-cycle property can show is the density of ones over a whole period. The bench measures that by counting ones across a full 65535-cycle period at mid-scale and full-scale levels, and it also runs random load and enable patterns against its own model of the sequence.

// File: rtl/dither_pkg.sv
package dither_pkg;

  typedef struct packed {
    logic advance;
    logic takeLevel;
    logic clearOut;
  } ctrlStrobes_t;

endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
(
  input  logic         enable,
  input  logic         levelLoad,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.advance   = enable;
    strobes.takeLevel = levelLoad;
    strobes.clearOut  = !enable;
  end

endmodule

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
  parameter int          LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [LFSR_W-1:0] state
);

  logic feedback;

  // Fibonacci feedback: XOR of all tapped bits (single reduction tree)
  assign feedback = ^(state & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (advance) begin
      state <= {state[LFSR_W-2:0], feedback};
    end
  end

endmodule

// File: rtl/dither_datapath.sv
module dither_datapath
  import dither_pkg::*;
#(
  parameter int          LEVEL_W  = 8,
  parameter int          LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [LEVEL_W-1:0] levelIn,
  output logic [LFSR_W-1:0]  lfsrState,
  output logic [LEVEL_W-1:0] levelReg,
  output logic               pulseOut
);

  logic [LEVEL_W-1:0] randVal;
  logic               hit;

  dither_lfsr #(
    .LFSR_W  (LFSR_W),
    .TAP_MASK(TAP_MASK),
    .SEED    (SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .advance(strobes.advance),
    .state  (lfsrState)
  );

  assign randVal = lfsrState[LEVEL_W-1:0];
  assign hit     = (randVal < levelReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      levelReg <= '0;
    end else if (strobes.takeLevel) begin
      levelReg <= levelIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseOut <= 1'b0;
    end else if (strobes.clearOut) begin
      pulseOut <= 1'b0;
    end else if (strobes.advance) begin
      pulseOut <= hit;
    end
  end

endmodule

// File: rtl/lfsr_dither_pwm.sv
module lfsr_dither_pwm
  import dither_pkg::*;
#(
  parameter int          LEVEL_W  = 8,
  parameter int          LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [LEVEL_W-1:0] levelIn,
  input  logic               levelLoad,
  output logic               pulseOut
);

  ctrlStrobes_t       strobes;
  logic [LFSR_W-1:0]  lfsrState;
  logic [LEVEL_W-1:0] levelReg;

  dither_ctrl u_ctrl (
    .enable   (enable),
    .levelLoad(levelLoad),
    .strobes  (strobes)
  );

  dither_datapath #(
    .LEVEL_W (LEVEL_W),
    .LFSR_W  (LFSR_W),
    .TAP_MASK(TAP_MASK),
    .SEED    (SEED)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .levelIn  (levelIn),
    .lfsrState(lfsrState),
    .levelReg (levelReg),
    .pulseOut (pulseOut)
  );

endmodule

// File: rtl/lfsr_dither_pwm_checker.sv
module lfsr_dither_pwm_checker #(
  parameter int          LEVEL_W  = 8,
  parameter int          LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic [LEVEL_W-1:0] levelIn,
  input logic               levelLoad,
  input logic               pulseOut,
  input logic [LFSR_W-1:0]  lfsrState,
  input logic [LEVEL_W-1:0] levelReg
);

  assert_compare_R2: assert property (@(posedge clk) disable iff (rst)
    enable |=> pulseOut == ($past(lfsrState[LEVEL_W-1:0]) < $past(levelReg)));

  assert_level_load_R3: assert property (@(posedge clk) disable iff (rst)
    levelLoad |=> levelReg == $past(levelIn));

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !levelLoad |=> $stable(levelReg));

  assert_lfsr_step_R4: assert property (@(posedge clk) disable iff (rst)
    enable |=> lfsrState == {$past(lfsrState[LFSR_W-2:0]), ^($past(lfsrState) & TAP_MASK)});

  assert_disabled_low_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulseOut);

  assert_lfsr_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(lfsrState));

  assert_zero_level_R6: assert property (@(posedge clk) disable iff (rst)
    (levelReg == '0) |=> !pulseOut);

  assert_no_lockup_R8: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

endmodule

bind lfsr_dither_pwm lfsr_dither_pwm_checker #(
  .LEVEL_W (LEVEL_W),
  .LFSR_W  (LFSR_W),
  .TAP_MASK(TAP_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .levelIn  (levelIn),
  .levelLoad(levelLoad),
  .pulseOut (pulseOut),
  .lfsrState(lfsrState),
  .levelReg (levelReg)
);

// File: tb/lfsr_dither_pwm_bench.sv
module lfsr_dither_pwm_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [7:0] levelIn = 8'd0;
  logic       levelLoad = 1'b0;
  logic       pulseOut;

  int compared = 0;
  int mismatched = 0;
  int onesSeen = 0;
  bit done = 1'b0;

  logic [15:0] model = 16'hACE1;
  logic [7:0]  modelLevel = 8'd0;

  always #10 clk = ~clk;  // 50 MHz

  lfsr_dither_pwm u_lfsr_dither_pwm (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .levelIn  (levelIn),
    .levelLoad(levelLoad),
    .pulseOut (pulseOut)
  );

  function automatic logic [15:0] nextState(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic int periodOnes(input int lvl);
    return (lvl == 0) ? 0 : 256 * lvl - 1;
  endfunction

  task automatic check(input int actual, input int expected, input string req);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Called at a falling edge; drives inputs, steps one clock, checks at next falling edge.
  task automatic step(input logic en, input logic ld, input logic [7:0] lvl, input string req);
    logic expOut;
    expOut = en ? (model[7:0] < modelLevel) : 1'b0;
    enable = en;
    levelLoad = ld;
    levelIn = lvl;
    if (en) model = nextState(model);
    if (ld) modelLevel = lvl;
    @(posedge clk);
    @(negedge clk);
    check(int'(pulseOut), int'(expOut), req);
    if (pulseOut) onesSeen++;
  endtask

  task automatic applyReset();
    rst = 1'b1;
    enable = 1'b0;
    levelLoad = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(pulseOut), 0, "R1 reset output");
    model = 16'hACE1;
    modelLevel = 8'd0;
    rst = 1'b0;
  endtask

  task automatic fullPeriod(input logic [7:0] lvl, input string req);
    step(1'b0, 1'b1, lvl, "R3 load while disabled");
    onesSeen = 0;
    for (int i = 0; i < 65535; i++) step(1'b1, 1'b0, 8'd0, "R2 per-cycle");
    check(onesSeen, periodOnes(int'(lvl)), req);
  endtask

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    applyReset();

    // R1: after reset the held level is 0, so enabled cycles give zeros
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'd0, "R1 R6 level zero after reset");

    // R3: level loaded at one edge affects only the next enabled edge
    step(1'b1, 1'b1, 8'd200, "R3 load edge uses old level");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 8'd0, "R3 R4 new level applies");

    // R5: disabled cycles force low and freeze the sequence
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 8'd0, "R5 disabled low");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 8'd0, "R5 resume sequence");

    // R6: zero level over a long stretch
    step(1'b1, 1'b1, 8'd0, "R6 load zero");
    onesSeen = 0;
    for (int i = 0; i < 400; i++) step(1'b1, 1'b0, 8'd0, "R6 zero level");
    check(onesSeen, 0, "R6 no ones at level zero");

    // R7: mid-scale density over a full period
    fullPeriod(8'd100, "R7 period ones at level 100");

    // R9: full-scale density over a full period
    fullPeriod(8'd255, "R9 period ones at level 255");

    // R1: reset mid-run restarts from the seed
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'd0, "R2 before reset");
    applyReset();
    step(1'b1, 1'b1, 8'd128, "R1 seed after reset");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 8'd0, "R1 R4 sequence from seed");

    // Constrained random load/enable mix
    for (int i = 0; i < 2000; i++) begin
      logic en, ld;
      logic [7:0] lv;
      en = ($urandom % 4) != 0;
      ld = ($urandom % 8) == 0;
      lv = 8'($urandom);
      step(en, ld, lv, "R2 R3 R5 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule